// File: doc/BRIEF.md
# Thresholded Event Counter with Qualification

This block is one hardware performance-monitoring counter. Every cycle it receives a vector of sub-event strobes from each of two hardware threads. It also receives each thread's privilege mode (kernel or user) and whether each thread is active. A selector register decides which strobes take part and, for each thread, in which privilege mode that thread's strobes count. A configuration register controls how the per-cycle event total is turned into a counter increment:

- the total is added as it is (raw mode), or
- it is compared against a 4-bit threshold, with a sense bit that can invert the comparison, so that a qualifying cycle adds one, or
- only rising edges of that comparison add one.

The configuration register also picks which thread-activity condition allows counting. Counting can be held off until a partner counter overflows.

The counter is 40 bits wide. When it wraps from all ones to zero, it sets a sticky overflow flag and raises a one-cycle interrupt pulse to each thread whose interrupt enable is set. A force mode raises those pulses on every increment. A small write/read port programs both registers and reads or presets the counter. Register reads are combinational from the current state.

Top module: `evt_thresh_ctr`

## Requirements
- R1: Address 0 is the selector, address 1 is the configuration, address 2 is count bits 31..0 and address 3 is count bits 39..32 (in the read's low 8 bits). Reserved bits read zero and ignore writes: selector bit 31, and configuration bits 29..28 and 11..0. Every register resets to zero.
- R2: Thread 0's strobes count only if its kernel flag is high and selector bit 3 is set, or its kernel flag is low and selector bit 2 is set. For thread 1 the bits are 1 (kernel) and 0 (user).
- R3: Selector bits 24..9 mask the strobes (bit 9+i passes strobe i). With configuration bit 18 clear, the counter adds the number of passing strobes of both threads in that cycle.
- R4: With configuration bit 12 (enable) clear, the count does not change except through a counter write.
- R5: Configuration bits 17..16 gate counting by the number of active threads: 00 needs zero, 01 needs exactly one, 10 needs both, 11 needs at least one.
- R6: With bit 18 set, a cycle adds one if the total exceeds the threshold in bits 23..20. When bit 19 is also set, the cycle instead qualifies if the total is at most the threshold.
- R7: With bits 18 and 24 set, one is added only on a cycle whose comparison result is true while the previous enabled cycle's result was false. A run of qualifying cycles therefore adds exactly one.
- R8: An increment that carries the count past all ones sets configuration bit 31. That flag stays set until a configuration write with bit 31 clear. If the wrap and such a write fall in the same cycle, the flag ends set.
- R9: The irq outputs pulse high for one cycle, one cycle after a wrapping increment: thread 0 if configuration bit 26 is set, thread 1 if bit 27 is set.
- R10: With configuration bit 25 set, every cycle with a nonzero increment pulses each enabled irq in the same way.
- R11: With configuration bit 30 set, the count holds until a cycle after partner_ovf has been seen high. Any configuration write re-arms this wait.
- R12: A counter write replaces its field and suppresses that cycle's increment, wrap and force pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_evt_t0 | input | 16 | Thread 0 sub-event strobes |
| sub_evt_t1 | input | 16 | Thread 1 sub-event strobes |
| kern_t0 | input | 1 | Thread 0 is in kernel mode |
| kern_t1 | input | 1 | Thread 1 is in kernel mode |
| active_t0 | input | 1 | Thread 0 is active |
| active_t1 | input | 1 | Thread 1 is active |
| partner_ovf | input | 1 | Partner counter overflow pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data |
| irq_t0 | output | 1 | Thread 0 interrupt pulse |
| irq_t1 | output | 1 | Thread 1 interrupt pulse |

## Verification
The wrap of the counter and a software write that clears the overflow flag can land in the same cycle. The bench provokes this by presetting the count to all ones, then issuing the clearing configuration write in the very cycle a single strobe arrives. The reference model lets the hardware set win, so the flag must read back set and the enabled interrupt must pulse. A counter preset that coincides with a counting cycle is judged the same way: the written value must appear, with no increment.

// File: rtl/etc_pkg.sv
package etc_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    A_SEL    = 2'd0,
    A_CFG    = 2'd1,
    A_CNT_LO = 2'd2,
    A_CNT_HI = 2'd3
  } reg_addr_e;

  localparam logic [REG_W-1:0] SEL_KEEP = 32'h7FFF_FFFF;
  localparam logic [REG_W-1:0] CFG_KEEP = 32'hCFFF_F000;

  // selector bit positions
  localparam int S_T1U = 0;
  localparam int S_T1K = 1;
  localparam int S_T0U = 2;
  localparam int S_T0K = 3;
  localparam int S_MASK_LO = 9;

  // configuration bit positions
  localparam int C_EN     = 12;
  localparam int C_ACT_LO = 16;
  localparam int C_CMP    = 18;
  localparam int C_CPL    = 19;
  localparam int C_THR_LO = 20;
  localparam int C_EDGE   = 24;
  localparam int C_FORCE  = 25;
  localparam int C_PMI0   = 26;
  localparam int C_PMI1   = 27;
  localparam int C_CASC   = 30;
  localparam int C_OVF    = 31;

  typedef struct packed {
    logic       en;
    logic       cmp;
    logic       cpl;
    logic       edg;
    logic       force_ovf;
    logic       pmi0;
    logic       pmi1;
    logic       casc;
    logic [1:0] act_mode;
    logic [3:0] thr;
  } cfg_ctl_t;
endpackage

// File: rtl/etc_evt_sum.sv
module etc_evt_sum #(
  parameter int NTHR  = 2,
  parameter int NSUB  = 16,
  parameter int SUM_W = 6
) (
  input  logic [NTHR-1:0][NSUB-1:0] strobes,
  input  logic [NTHR-1:0]           thr_en,
  input  logic [NSUB-1:0]           mask,
  output logic [SUM_W-1:0]          total
);
  logic [SUM_W-1:0] part [NTHR];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    always_comb begin
      part[t] = '0;
      for (int b = 0; b < NSUB; b++) begin
        part[t] = part[t] + SUM_W'(strobes[t][b] & mask[b] & thr_en[t]);
      end
    end
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < NTHR; t++) begin
      total = total + part[t];
    end
  end
endmodule

// File: rtl/etc_qualify.sv
module etc_qualify
  import etc_pkg::*;
#(
  parameter int NTHR  = 2,
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_ctl_t         ctl,
  input  logic [NTHR-1:0]  act,
  input  logic [SUM_W-1:0] total,
  output logic [SUM_W-1:0] inc
);
  logic prev_q, prev_d;
  logic count_gt, qual, edge_hit, act_ok;
  logic [SUM_W-1:0] inc_raw;

  always_comb begin
    count_gt = total > SUM_W'(ctl.thr);
    if (ctl.cmp) qual = ctl.cpl ? !count_gt : count_gt;
    else         qual = (total != '0);
    edge_hit = qual & ~prev_q;
    unique case (ctl.act_mode)
      2'b00:   act_ok = (act == '0);
      2'b01:   act_ok = ($countones(act) == 1);
      2'b10:   act_ok = (act == '1);
      default: act_ok = (act != '0);
    endcase
    if (!ctl.cmp) inc_raw = total;
    else          inc_raw = SUM_W'(ctl.edg ? edge_hit : qual);
    inc    = (ctl.en && act_ok) ? inc_raw : '0;
    prev_d = ctl.en ? qual : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && ctl.cmp && ctl.edg && edge_hit) |=> !edge_hit); // R7
  AST_IDLE_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.act_mode == 2'b00 && act != '0) |-> (inc == '0)); // R5
endmodule

// File: rtl/etc_ctr_core.sv
module etc_ctr_core
  import etc_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SUM_W-1:0] inc,
  input  logic             casc,
  input  logic             force_ovf,
  input  logic             pmi0,
  input  logic             pmi1,
  input  logic             partner_ovf,
  input  logic             cfg_wr,
  input  logic             cnt_wr_lo,
  input  logic             cnt_wr_hi,
  input  logic [REG_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             irq0,
  output logic             irq1
);
  localparam int HI_W = CNT_W - REG_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic [SUM_W-1:0] step;
  logic             armed_q, armed_d;
  logic             irq0_q, irq0_d, irq1_q, irq1_d;
  logic             cnt_wr, fire;

  always_comb begin
    cnt_wr  = cnt_wr_lo | cnt_wr_hi;
    armed_d = cfg_wr ? 1'b0 : (partner_ovf ? 1'b1 : armed_q);
    step    = (!casc || armed_q) ? inc : '0;
    sum     = {1'b0, cnt_q} + {{(CNT_W + 1 - SUM_W){1'b0}}, step};
    wrap    = sum[CNT_W] & ~cnt_wr;
    cnt_d   = sum[CNT_W-1:0];
    if (cnt_wr) begin
      cnt_d = cnt_q;
      if (cnt_wr_lo) cnt_d[REG_W-1:0]     = wr_data;
      if (cnt_wr_hi) cnt_d[CNT_W-1:REG_W] = wr_data[HI_W-1:0];
    end
    fire   = wrap | (force_ovf & (step != '0) & ~cnt_wr);
    irq0_d = pmi0 & fire;
    irq1_d = pmi1 & fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      irq0_q  <= 1'b0;
      irq1_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      irq0_q  <= irq0_d;
      irq1_q  <= irq1_d;
    end
  end

  assign cnt  = cnt_q;
  assign irq0 = irq0_q;
  assign irq1 = irq1_q;

  AST_CASCADE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !armed_q && !cnt_wr) |=> $stable(cnt_q)); // R11
  AST_IRQ0_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq0_q |-> $past(pmi0)); // R9
  AST_IRQ1_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq1_q |-> $past(pmi1)); // R9
  AST_NO_INC_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_lo && !cnt_wr_hi) |=> (cnt_q[CNT_W-1:REG_W] == $past(cnt_q[CNT_W-1:REG_W]))); // R12
endmodule

// File: rtl/evt_thresh_ctr.sv
module evt_thresh_ctr
  import etc_pkg::*;
#(
  parameter int NSUB  = 16,
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSUB-1:0]  sub_evt_t0,
  input  logic [NSUB-1:0]  sub_evt_t1,
  input  logic             kern_t0,
  input  logic             kern_t1,
  input  logic             active_t0,
  input  logic             active_t1,
  input  logic             partner_ovf,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [1:0]       rd_addr,
  output logic [31:0]      rd_data,
  output logic             irq_t0,
  output logic             irq_t1
);
  localparam int NTHR  = 2;
  localparam int SUM_W = $clog2(NTHR * NSUB + 1);
  localparam int HI_W  = CNT_W - REG_W;

  logic [REG_W-1:0] sel_q, sel_d, cfg_q, cfg_d;
  logic             sel_wr, cfg_wr, cnt_wr_lo, cnt_wr_hi;
  cfg_ctl_t         ctl;
  logic [NTHR-1:0][NSUB-1:0] strobes;
  logic [NTHR-1:0]  thr_en;
  logic [NSUB-1:0]  mask;
  logic [SUM_W-1:0] total, inc;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  always_comb begin
    sel_wr    = wr_en && (reg_addr_e'(wr_addr) == A_SEL);
    cfg_wr    = wr_en && (reg_addr_e'(wr_addr) == A_CFG);
    cnt_wr_lo = wr_en && (reg_addr_e'(wr_addr) == A_CNT_LO);
    cnt_wr_hi = wr_en && (reg_addr_e'(wr_addr) == A_CNT_HI);
  end

  always_comb begin
    ctl.en        = cfg_q[C_EN];
    ctl.cmp       = cfg_q[C_CMP];
    ctl.cpl       = cfg_q[C_CPL];
    ctl.edg       = cfg_q[C_EDGE];
    ctl.force_ovf = cfg_q[C_FORCE];
    ctl.pmi0      = cfg_q[C_PMI0];
    ctl.pmi1      = cfg_q[C_PMI1];
    ctl.casc      = cfg_q[C_CASC];
    ctl.act_mode  = cfg_q[C_ACT_LO +: 2];
    ctl.thr       = cfg_q[C_THR_LO +: 4];
  end

  always_comb begin
    strobes[0] = sub_evt_t0;
    strobes[1] = sub_evt_t1;
    thr_en[0]  = kern_t0 ? sel_q[S_T0K] : sel_q[S_T0U];
    thr_en[1]  = kern_t1 ? sel_q[S_T1K] : sel_q[S_T1U];
    mask       = sel_q[S_MASK_LO +: NSUB];
  end

  etc_evt_sum #(.NTHR(NTHR), .NSUB(NSUB), .SUM_W(SUM_W)) u_sum (
    .strobes (strobes),
    .thr_en  (thr_en),
    .mask    (mask),
    .total   (total)
  );

  etc_qualify #(.NTHR(NTHR), .SUM_W(SUM_W)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .act   ({active_t1, active_t0}),
    .total (total),
    .inc   (inc)
  );

  etc_ctr_core #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc         (inc),
    .casc        (ctl.casc),
    .force_ovf   (ctl.force_ovf),
    .pmi0        (ctl.pmi0),
    .pmi1        (ctl.pmi1),
    .partner_ovf (partner_ovf),
    .cfg_wr      (cfg_wr),
    .cnt_wr_lo   (cnt_wr_lo),
    .cnt_wr_hi   (cnt_wr_hi),
    .wr_data     (wr_data),
    .cnt         (cnt),
    .wrap        (wrap),
    .irq0        (irq_t0),
    .irq1        (irq_t1)
  );

  always_comb begin
    sel_d = sel_wr ? (wr_data & SEL_KEEP) : sel_q;
    cfg_d = cfg_wr ? (wr_data & CFG_KEEP) : cfg_q;
    if (wrap) cfg_d[C_OVF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cfg_q <= '0;
    end else begin
      sel_q <= sel_d;
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      A_SEL:    rd_data = sel_q;
      A_CFG:    rd_data = cfg_q;
      A_CNT_LO: rd_data = cnt[REG_W-1:0];
      default:  rd_data = {{(REG_W - HI_W){1'b0}}, cnt[CNT_W-1:REG_W]};
    endcase
  end

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cfg_q[C_OVF]); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[C_OVF] && !cfg_wr) |=> cfg_q[C_OVF]); // R8
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[C_EN] && !cnt_wr_lo && !cnt_wr_hi) |=> $stable(cnt)); // R4
endmodule

// File: tb/evt_thresh_ctr_bench.sv
module evt_thresh_ctr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] sub0, sub1;
  logic        k0, k1, a0, a1, pov;
  logic        wr_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        irq0, irq1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_sel, m_cfg;
  logic [39:0] m_cnt;
  bit          m_armed, m_prev, m_irq0, m_irq1;

  always #2 clk = ~clk;

  evt_thresh_ctr u_evt_thresh_ctr (
    .clk(clk), .rst_n(rst_n), .sub_evt_t0(sub0), .sub_evt_t1(sub1),
    .kern_t0(k0), .kern_t1(k1), .active_t0(a0), .active_t1(a1),
    .partner_ovf(pov), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_t0(irq0), .irq_t1(irq1)
  );

  task automatic model_update();
    int tot, nact, inc, stp;
    bit ok, qual, cwr, wr_wrap, fire, en, e0, e1;
    logic [40:0] nxt;
    tot = 0;
    e0 = k0 ? m_sel[3] : m_sel[2];
    e1 = k1 ? m_sel[1] : m_sel[0];
    for (int b = 0; b < 16; b++) begin
      if (e0 && sub0[b] && m_sel[9+b]) tot++;
      if (e1 && sub1[b] && m_sel[9+b]) tot++;
    end
    nact = int'(a0) + int'(a1);
    case (m_cfg[17:16])
      2'b00: ok = (nact == 0);
      2'b01: ok = (nact == 1);
      2'b10: ok = (nact == 2);
      default: ok = (nact >= 1);
    endcase
    en = m_cfg[12];
    if (m_cfg[18]) qual = m_cfg[19] ? (tot <= int'(m_cfg[23:20])) : (tot > int'(m_cfg[23:20]));
    else qual = (tot != 0);
    if (!m_cfg[18]) inc = tot;
    else if (m_cfg[24]) inc = (qual && !m_prev) ? 1 : 0;
    else inc = qual ? 1 : 0;
    stp = (en && ok && (!m_cfg[30] || m_armed)) ? inc : 0;
    cwr = wr_en && (wr_addr >= 2'd2);
    nxt = {1'b0, m_cnt} + 41'(stp);
    wr_wrap = !cwr && nxt[40];
    fire = wr_wrap || (m_cfg[25] && stp > 0 && !cwr);
    m_irq0 = m_cfg[26] && fire;
    m_irq1 = m_cfg[27] && fire;
    m_prev = en ? qual : 1'b0;
    if (wr_en && wr_addr == 2'd1) m_armed = 1'b0;
    else if (pov) m_armed = 1'b1;
    if (cwr) begin
      if (wr_addr == 2'd2) m_cnt[31:0] = wr_data;
      else m_cnt[39:32] = wr_data[7:0];
    end else m_cnt = nxt[39:0];
    if (wr_en && wr_addr == 2'd0) m_sel = wr_data & 32'h7FFF_FFFF;
    if (wr_en && wr_addr == 2'd1) m_cfg = wr_data & 32'hCFFF_F000;
    if (wr_wrap) m_cfg[31] = 1'b1;
  endtask

  function automatic logic [31:0] exp_rd();
    case (rd_addr)
      2'd0: return m_sel;
      2'd1: return m_cfg;
      2'd2: return m_cnt[31:0];
      default: return {24'h0, m_cnt[39:32]};
    endcase
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (rd_data !== exp_rd()) begin
      n_fail++;
      $display("FAIL %s rd_data addr %0d actual %h expected %h", tag, rd_addr, rd_data, exp_rd());
    end
    n_chk++;
    if (irq0 !== m_irq0 || irq1 !== m_irq1) begin
      n_fail++;
      $display("FAIL %s irq actual %b%b expected %b%b", tag, irq1, irq0, m_irq1, m_irq0);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(tag);
    wr_en = 1'b0;
    pov = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(tag);
  endtask

  task automatic ev(input logic [15:0] s0, input logic [15:0] s1, input string tag);
    sub0 = s0; sub1 = s1;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sub0 = '0; sub1 = '0; k0 = 0; k1 = 0; a0 = 1; a1 = 1; pov = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 2'd2;
    m_sel = '0; m_cfg = '0; m_cnt = '0; m_armed = 0; m_prev = 0; m_irq0 = 0; m_irq1 = 0;
    repeat (3) @(negedge clk);
    // R1 reset state on every address
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1 check("R1 reset");
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reserved bits
    rd_addr = 2'd0; wr(2'd0, 32'hFFFF_FFFF, "R1 sel rsvd");
    rd_addr = 2'd1; wr(2'd1, 32'hFFFF_FFFF, "R1 cfg rsvd");
    wr(2'd1, 32'h0, "R1 cfg clear");

    // R3 raw counting, mask and both threads
    rd_addr = 2'd0; wr(2'd0, (32'h00FF << 9) | 32'hF, "R3 sel");
    rd_addr = 2'd2; wr(2'd1, (32'h3 << 16) | (32'h1 << 12), "R3 cfg");
    ev(16'hFFFF, 16'h0000, "R3 t0 masked");
    ev(16'h00F0, 16'h0F0F, "R3 both");
    ev(16'hFF00, 16'hFF00, "R3 masked out");
    wr(2'd0, (32'hFFFF << 9) | 32'hF, "R3 full mask");
    ev(16'hFFFF, 16'hFFFF, "R3 max total");

    // R2 privilege enables
    wr(2'd0, (32'hFFFF << 9) | 32'h4, "R2 t0 user only");
    k0 = 0; k1 = 0; ev(16'h000F, 16'h00FF, "R2 t0 user");
    k0 = 1; ev(16'h000F, 16'h00FF, "R2 t0 kernel blocked");
    wr(2'd0, (32'hFFFF << 9) | 32'h2, "R2 t1 kernel only");
    k1 = 1; ev(16'h0003, 16'h0007, "R2 t1 kernel");
    k1 = 0; ev(16'h0003, 16'h0007, "R2 t1 user blocked");
    wr(2'd0, (32'hFFFF << 9) | 32'hF, "R2 all");
    k0 = 0; k1 = 0;

    // R4 enable off holds
    wr(2'd1, (32'h3 << 16), "R4 disable");
    ev(16'hFFFF, 16'hFFFF, "R4 hold");
    ev(16'h0101, 16'h1010, "R4 hold");

    // R5 activity modes
    for (int m = 0; m < 4; m++) begin
      wr(2'd1, (32'(m) << 16) | (32'h1 << 12), "R5 mode");
      for (int c = 0; c < 4; c++) begin
        a0 = c[0]; a1 = c[1];
        ev(16'h0003, 16'h0001, "R5 gate");
      end
    end
    a0 = 1; a1 = 1;

    // R6 threshold compare, both senses
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 18) | (32'h3 << 20), "R6 gt3");
    ev(16'h0007, 16'h0000, "R6 total3");
    ev(16'h000F, 16'h0000, "R6 total4");
    ev(16'hFFFF, 16'hFFFF, "R6 total32");
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h3 << 18) | (32'h3 << 20), "R6 le3");
    ev(16'h0007, 16'h0000, "R6 cpl total3");
    ev(16'h0000, 16'h0000, "R6 cpl total0");
    ev(16'h001F, 16'h0000, "R6 cpl total5");

    // R7 edge detection
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 18) | (32'h1 << 20) | (32'h1 << 24), "R7 edge");
    ev(16'h0007, 16'h0, "R7 rise");
    ev(16'h0007, 16'h0, "R7 run");
    ev(16'h00FF, 16'h0, "R7 run");
    ev(16'h0001, 16'h0, "R7 fall");
    ev(16'h0003, 16'h0003, "R7 rise again");

    // R8 R9 wrap, flag and interrupt; clear in same cycle as wrap
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 26), "R9 cfg");
    rd_addr = 2'd3; wr(2'd3, 32'hFF, "R8 preset hi");
    rd_addr = 2'd2; wr(2'd2, 32'hFFFF_FFFE, "R8 preset lo");
    ev(16'h0001, 16'h0, "R8 near");
    rd_addr = 2'd1;
    sub0 = 16'h0001;
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 26), "R8 wrap vs clear");
    sub0 = 16'h0;
    ev(16'h0, 16'h0, "R8 sticky");
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h3 << 26), "R8 clear");
    rd_addr = 2'd2; wr(2'd2, 32'hFFFF_FFFF, "R9 preset");
    rd_addr = 2'd3; wr(2'd3, 32'hFF, "R9 preset hi");
    ev(16'h0003, 16'h0, "R9 wrap both");
    ev(16'h0, 16'h0, "R9 pulse ends");

    // R10 force
    rd_addr = 2'd2;
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 25) | (32'h1 << 27), "R10 cfg");
    ev(16'h0001, 16'h0, "R10 inc");
    ev(16'h0, 16'h0, "R10 no inc");
    ev(16'h0011, 16'h0, "R10 inc");

    // R12 counter write concurrent with counting
    sub0 = 16'hFFFF;
    wr(2'd2, 32'h1234_5678, "R12 write wins");
    ev(16'h0, 16'h0, "R12 after");

    // R11 cascade
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 30), "R11 cfg");
    ev(16'h00FF, 16'h0, "R11 idle");
    pov = 1'b1; ev(16'h00FF, 16'h0, "R11 partner seen");
    ev(16'h00FF, 16'h0, "R11 counting");
    wr(2'd1, (32'h3 << 16) | (32'h1 << 12) | (32'h1 << 30), "R11 rearm");
    ev(16'h00FF, 16'h0, "R11 idle again");

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      sub0 = 16'($urandom); sub1 = 16'($urandom);
      k0 = 1'($urandom); k1 = 1'($urandom);
      a0 = 1'($urandom); a1 = 1'($urandom);
      pov = ($urandom % 16) == 0;
      rd_addr = 2'($urandom);
      if (($urandom % 8) == 0) begin
        wr_en = 1'b1; wr_addr = 2'($urandom); wr_data = $urandom;
        if (wr_addr == 2'd1) wr_data[12] = 1'b1;
      end
      step("R3 R6 R11 mixed");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule